// File: doc/BRIEF.md
# Eight-Channel ADC Conversion Controller

This block puts an eight-input, 10-bit sampling converter behind a 32-bit register port with a control/status word and a result word. Software picks an input, turns the module on and writes the start bit. The block then sends a one-cycle start strobe and the latched input number to the converter side. It produces the converter's bit clock from a programmable divider and waits for the converter's done pulse. On that pulse it stores the result, drops the busy indication and raises a status flag. If the interrupt mask allows it, the flag drives the interrupt line. A synthesizable behavioural converter model sits inside the block. It returns the code that is present on the matching `ain_codes` slice after a fixed number of bit-clock periods.

Sequencing is done by a three-state machine. **IDLE** waits for an accepted start request and moves to **STROBE** (transition *launch*). **STROBE** holds the start strobe for exactly one cycle and moves to **BUSY** (transition *issue*), or back to IDLE when the module is off or in soft reset (transition *abort*). **BUSY** returns to IDLE either on the converter's done pulse (transition *complete*, which captures the result) or on *abort*. The start bit reads back as one in STROBE and BUSY, so it also serves as the busy flag. A soft-reset bit clears the whole block and holds it cleared.

Top module: `adc_regif_top`

## Requirements
- R1: Control word sits at byte offset 0x00 and result word at 0x04. Control fields: input select 27:24, interrupt mask 21, reference select 19, done status 18, module on 17, soft reset 16, start/busy 13, divider 8:1. The result occupies 9:0 of the result word with zeros above. After reset both words read zero, and `irq`, `ref_internal` and `conv_clk` are low.
- R2: A control write with bit 13 and bit 17 both one, bit 16 zero and no conversion running starts a conversion. In the cycle after that write, `conv_start` is high for exactly one cycle and `conv_chan` carries the low three bits of the select field. Bit 13 reads one until the conversion finishes.
- R3: At completion, the result word takes the selected input's code on the same clock edge that sets bit 18, and bit 13 reads zero from then on.
- R4: `irq` is high exactly while bit 18 and bit 21 are both one.
- R5: A control write with bit 18 at one clears the status. A write with bit 18 at zero leaves the status unchanged.
- R6: While the module is on, `conv_clk` has a period of 2 × (divider + 1) input clock cycles.
- R7: A conversion spans 12 bit-clock periods. Status becomes visible between 11P+3 and 12P+2 input clock edges after the start write, where P = 2 × (divider + 1).
- R8: `ref_internal` follows bit 19: 1 selects the internal reference and 0 the external one.
- R9: A start write whose own bit 17 is zero starts nothing. No strobe is sent, bit 13 stays zero, and status and result are unchanged.
- R10: Writing bit 17 to zero during a conversion aborts it. Bit 13 drops within two cycles, status is not set and the result word keeps its old value.
- R11: A control write with bit 16 at one clears every field, the status and the result word, and the control word then reads 0x0001_0000. A later write with bit 16 at zero releases the block.
- R12: A change of the select field during a conversion does not affect that conversion. It applies from the next start onward, and the field reads back the new value at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (3) | Byte address, bit 2 selects result word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Completion interrupt |
| ref_internal | output | 1 | Reference choice, 1 = internal |
| conv_clk | output | 1 | Converter bit clock |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | 3 | Input number held for the running conversion |
| ain_codes | input | NUM_CH × RES_W (80) | Code each input would convert to, input i in slice i |

## Verification
On every cycle, the embedded assertions check the following: the strobe lasts one cycle and is only sent to an idle converter; the latched input number stays fixed through BUSY; the capture edge sets status and loads the converter's data; an abort or a start without the module bit leaves the machine idle; a write-one clear takes effect; and soft reset keeps status, result and interrupt at zero. Other properties can only be shown by the directed scenarios, because they depend on elapsed time or on the external stimulus: the bit-clock period for several dividers, the conversion latency window, which input's code actually lands in the result word, and the way a mid-conversion select change takes effect only on the following conversion.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

    // Control word bit positions (software visible layout)
    localparam int CHF_LSB = 24;
    localparam int CHF_W   = 4;
    localparam int IE_BIT  = 21;
    localparam int REF_BIT = 19;
    localparam int ST_BIT  = 18;
    localparam int EN_BIT  = 17;
    localparam int SR_BIT  = 16;
    localparam int GO_BIT  = 13;
    localparam int DIV_LSB = 1;
    localparam int DIV_W   = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_BUSY   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [CHF_W-1:0] chan;
        logic             ie;
        logic             refint;
        logic             en;
        logic             srst;
        logic [DIV_W-1:0] div;
    } ctrl_t;

endpackage

// File: rtl/adc_convclk.sv
module adc_convclk #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic             conv_clk,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             clk_q;
    logic             wrap;

    assign wrap = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign conv_clk = clk_q;
    // marks the edge on which the bit clock rises
    assign tick     = run && wrap && !clk_q;

endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
    parameter int RES_W       = 10,
    parameter int NUM_CH      = 8,
    parameter int CONV_CYCLES = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    abort,
    input  logic                    start,
    input  logic [$clog2(NUM_CH)-1:0] chan,
    input  logic                    tick,
    input  logic [NUM_CH*RES_W-1:0] codes,
    output logic                    done,
    output logic [RES_W-1:0]        data
);

    localparam int CH_SEL_W = $clog2(NUM_CH);
    localparam int CNT_W    = $clog2(CONV_CYCLES + 1);

    logic                active_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CH_SEL_W-1:0] ch_q;
    logic                done_q;
    logic [RES_W-1:0]    data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            ch_q     <= '0;
            done_q   <= 1'b0;
            data_q   <= '0;
        end else if (abort) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                ch_q     <= chan;
            end else if (active_q && tick) begin
                if (cnt_q == CNT_W'(CONV_CYCLES - 1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    data_q   <= codes[int'(ch_q)*RES_W +: RES_W];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign data = data_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q); // R2

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_regif_pkg::*;
#(
    parameter int CH_SEL_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                go,
    input  logic [CH_SEL_W-1:0] chan_in,
    input  logic                conv_done,
    output logic                conv_start,
    output logic [CH_SEL_W-1:0] conv_chan,
    output logic                busy,
    output logic                capture
);

    seq_state_t          state_q, state_d;
    logic [CH_SEL_W-1:0] chan_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (go) state_d = SEQ_STROBE;              // launch
            SEQ_STROBE: state_d = clear ? SEQ_IDLE : SEQ_BUSY;     // abort / issue
            SEQ_BUSY:   if (clear || conv_done) state_d = SEQ_IDLE; // abort / complete
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          chan_q <= '0;
        else if (state_q == SEQ_IDLE && go)  chan_q <= chan_in;
    end

    always_comb begin
        conv_start = (state_q == SEQ_STROBE);
        busy       = (state_q != SEQ_IDLE);
        capture    = (state_q == SEQ_BUSY) && conv_done && !clear;
        conv_chan  = chan_q;
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(conv_chan)); // R12
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && busy) |=> !busy); // R10

endmodule

// File: rtl/adc_regif_top.sv
module adc_regif_top
    import adc_regif_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int NUM_CH      = 8,
    parameter int CONV_CYCLES = 12,
    parameter int ADDR_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         irq,
    output logic                         ref_internal,
    output logic                         conv_clk,
    output logic                         conv_start,
    output logic [$clog2(NUM_CH)-1:0]    conv_chan,
    input  logic [NUM_CH*RES_W-1:0]      ain_codes
);

    localparam int CH_SEL_W = $clog2(NUM_CH);

    ctrl_t            ctrl_q, wr_img;
    logic             status_q;
    logic [RES_W-1:0] data_q;
    logic             sel_data, wr_ctrl, wr_srst, go, clear;
    logic             busy, capture, tick, conv_done;
    logic [RES_W-1:0] conv_data;

    assign sel_data = bus_addr[2];
    assign wr_ctrl  = bus_wr && !sel_data;
    assign wr_srst  = wr_ctrl && bus_wdata[SR_BIT];
    assign clear    = !ctrl_q.en || ctrl_q.srst;
    assign go       = wr_ctrl && bus_wdata[GO_BIT] && bus_wdata[EN_BIT]
                      && !bus_wdata[SR_BIT] && !busy;

    always_comb begin
        wr_img        = '0;
        wr_img.chan   = bus_wdata[CHF_LSB +: CHF_W];
        wr_img.ie     = bus_wdata[IE_BIT];
        wr_img.refint = bus_wdata[REF_BIT];
        wr_img.en     = bus_wdata[EN_BIT];
        wr_img.div    = bus_wdata[DIV_LSB +: DIV_W];
    end

    adc_convclk #(.CNT_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!clear),
        .div      (ctrl_q.div),
        .conv_clk (conv_clk),
        .tick     (tick)
    );

    adc_seq_fsm #(.CH_SEL_W(CH_SEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .go         (go),
        .chan_in    (wr_img.chan[CH_SEL_W-1:0]),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .busy       (busy),
        .capture    (capture)
    );

    adc_conv_model #(
        .RES_W       (RES_W),
        .NUM_CH      (NUM_CH),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_model (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (clear),
        .start (conv_start),
        .chan  (conv_chan),
        .tick  (tick),
        .codes (ain_codes),
        .done  (conv_done),
        .data  (conv_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            status_q <= 1'b0;
            data_q   <= '0;
        end else if (wr_srst) begin
            ctrl_q      <= '0;
            ctrl_q.srst <= 1'b1;
            status_q    <= 1'b0;
            data_q      <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wr_img;
            if (capture) begin
                status_q <= 1'b1;
                data_q   <= conv_data;
            end else if (wr_ctrl && bus_wdata[ST_BIT]) begin
                status_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_data) begin
            bus_rdata[RES_W-1:0] = data_q;
        end else begin
            bus_rdata[CHF_LSB +: CHF_W] = ctrl_q.chan;
            bus_rdata[IE_BIT]           = ctrl_q.ie;
            bus_rdata[REF_BIT]          = ctrl_q.refint;
            bus_rdata[ST_BIT]           = status_q;
            bus_rdata[EN_BIT]           = ctrl_q.en;
            bus_rdata[SR_BIT]           = ctrl_q.srst;
            bus_rdata[GO_BIT]           = busy;
            bus_rdata[DIV_LSB +: DIV_W] = ctrl_q.div;
        end
    end

    assign irq          = status_q && ctrl_q.ie;
    assign ref_internal = ctrl_q.refint;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:28], bus_wdata[23:22],
                           bus_wdata[20], bus_wdata[15:14], bus_wdata[12:9],
                           bus_wdata[0], ctrl_q.chan[CHF_W-1:CH_SEL_W]};

    AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !wr_srst) |=> (status_q && !busy && data_q == $past(conv_data))); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[ST_BIT] && !capture) |=> !status_q); // R5
    AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.srst |-> (!status_q && data_q == '0 && !irq)); // R11
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[GO_BIT] && !bus_wdata[EN_BIT] && !busy) |=> !busy); // R9

endmodule

// File: tb/adc_regif_top_test.sv
module adc_regif_top_test;

    localparam logic [31:0] B_GO  = 32'h1 << 13;
    localparam logic [31:0] B_SR  = 32'h1 << 16;
    localparam logic [31:0] B_EN  = 32'h1 << 17;
    localparam logic [31:0] B_ST  = 32'h1 << 18;
    localparam logic [31:0] B_REF = 32'h1 << 19;
    localparam logic [31:0] B_IE  = 32'h1 << 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq, ref_internal, conv_clk, conv_start;
    logic [2:0]  conv_chan;
    logic [79:0] ain_codes;

    int n_cmp = 0;
    int n_bad = 0;
    int n_strobe = 0;
    logic [9:0] last_data = 10'd0;

    always #2 clk = ~clk;

    adc_regif_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .ref_internal(ref_internal), .conv_clk(conv_clk),
        .conv_start(conv_start), .conv_chan(conv_chan), .ain_codes(ain_codes)
    );

    always @(negedge clk) if (rst_n && conv_start) n_strobe++;

    function automatic logic [9:0] code_of(input int i);
        return 10'((i * 97 + 13) % 1024);
    endfunction

    function automatic logic [31:0] chsel(input int c);
        return 32'(c) << 24;
    endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = v;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // counts edges after the start write until the status bit is seen
    task automatic wait_status(output int n);
        logic [31:0] v;
        n = 0;
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk); n++;
            rd(3'd0, v);
            if (v[18]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1", "control after reset", v, 0);
        rd(3'd4, v); chk("R1", "result after reset", v, 0);
        chk("R1", "irq/ref/conv_clk after reset", {irq, ref_internal, conv_clk}, 0);
    endtask

    task automatic t_refsel();
        logic [31:0] v;
        wr(B_REF); rd(3'd0, v);
        chk("R8", "ref_internal set", ref_internal, 1);
        chk("R1", "ref readback", v, B_REF);
        wr(32'd0);
        chk("R8", "ref_internal clear", ref_internal, 0);
    endtask

    task automatic t_clock(input int d);
        int a, b, cyc;
        logic prev;
        wr(B_EN | (32'(d) << 1));
        a = -1; b = -1; cyc = 0; prev = conv_clk;
        for (int k = 0; k < 2000 && b < 0; k++) begin
            @(posedge clk); #1 cyc++;
            if (conv_clk && !prev) begin
                if (a < 0) a = cyc; else b = cyc;
            end
            prev = conv_clk;
        end
        chk("R6", $sformatf("bit clock period div=%0d", d), b - a, 2 * (d + 1));
        wr(32'd0);
    endtask

    task automatic t_convert(input int ch, input int d, input bit ie);
        logic [31:0] base, v;
        int n, p;
        base = B_EN | (ie ? B_IE : 32'd0) | (32'(d) << 1) | chsel(ch);
        p = 2 * (d + 1);
        wr(base | B_GO);
        chk("R2", "start strobe", conv_start, 1);
        chk("R2", "strobe input number", conv_chan, ch);
        rd(3'd0, v);
        chk("R2", "busy bit while converting", v[13], 1);
        wait_status(n);
        chk("R7", $sformatf("latency in window (n=%0d)", n),
            (n >= 11 * p + 3 && n <= 12 * p + 2), 1);
        rd(3'd4, v);
        chk("R3", "result on status edge", v, 32'(code_of(ch)));
        rd(3'd0, v);
        chk("R3", "busy cleared at completion", v[13], 0);
        chk("R4", "irq follows mask", irq, ie);
        last_data = code_of(ch);
        wr(base);
        rd(3'd0, v);
        chk("R5", "status kept by write of zero", v[18], 1);
        wr(base | B_ST);
        rd(3'd0, v);
        chk("R5", "status cleared by write of one", v[18], 0);
        chk("R4", "irq low after clear", irq, 0);
    endtask

    task automatic t_ignore_disabled();
        logic [31:0] v;
        int s0;
        s0 = n_strobe;
        wr(B_GO | B_IE | chsel(1));
        repeat (50) @(posedge clk);
        #1;
        chk("R9", "no strobe without enable", n_strobe, s0);
        rd(3'd0, v);
        chk("R9", "busy/status stay zero", {v[13], v[18]}, 0);
        rd(3'd4, v);
        chk("R9", "result unchanged", v, 32'(last_data));
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(B_EN | B_IE | chsel(4) | B_GO);
        repeat (5) @(posedge clk);
        wr(B_IE | chsel(4));
        repeat (2) @(posedge clk);
        rd(3'd0, v);
        chk("R10", "busy dropped after disable", v[13], 0);
        repeat (60) @(posedge clk);
        rd(3'd0, v);
        chk("R10", "no status after abort", v[18], 0);
        rd(3'd4, v);
        chk("R10", "result unchanged after abort", v, 32'(last_data));
    endtask

    task automatic t_chan_change();
        logic [31:0] v;
        int n;
        wr(B_EN | chsel(2) | B_GO);
        repeat (4) @(posedge clk);
        wr(B_EN | chsel(5));
        rd(3'd0, v);
        chk("R12", "select field reads new value", v[27:24], 5);
        chk("R12", "strobed number unchanged", conv_chan, 2);
        wait_status(n);
        rd(3'd4, v);
        chk("R12", "running conversion used old input", v, 32'(code_of(2)));
        wr(B_EN | chsel(5) | B_ST);
        wr(B_EN | chsel(5) | B_GO);
        wait_status(n);
        rd(3'd4, v);
        chk("R12", "next conversion uses new input", v, 32'(code_of(5)));
        last_data = code_of(5);
        wr(B_EN | chsel(5) | B_ST);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        int n;
        wr(B_EN | B_IE | B_REF | chsel(3) | (32'd7 << 1) | B_GO);
        wait_status(n);
        chk("R4", "irq raised before soft reset", irq, 1);
        wr(B_SR);
        repeat (3) @(posedge clk);
        rd(3'd0, v);
        chk("R11", "control during soft reset", v, B_SR);
        rd(3'd4, v);
        chk("R11", "result during soft reset", v, 0);
        chk("R11", "irq/ref/conv_clk during soft reset",
            {irq, ref_internal, conv_clk}, 0);
        wr(32'd0);
        rd(3'd0, v);
        chk("R11", "control after release", v, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ain_codes[i*10 +: 10] = code_of(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refsel();
        t_clock(0);
        t_clock(3);
        t_convert(3, 0, 1'b1);
        t_convert(6, 2, 1'b0);
        t_convert(0, 1, 1'b1);
        t_ignore_disabled();
        t_abort();
        t_chan_change();
        t_srst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule